// File: doc/BRIEF.md
# Eight-bit compare timer

This block is a small timer peripheral. An up-counter advances on every system clock edge at which a prescaled count-enable strobe is high. A two-bit mode field picks the counting sequence. In free-running mode the counter rolls over from its maximum back to zero. In match-clear mode the counter restarts from zero once it has reached the value held in a compare register.

Each time the count equals the compare value on a counting edge, the block raises a match flag. On the same edge it can drive a waveform pin in one of three ways: toggle it, clear it or set it. Separately, an overflow flag is raised on the edge at which the count rolls over from its maximum to zero. Hardware only sets the two flags. They are cleared by an acknowledge input or by a software write.

Software reaches the counter, the compare value, the control field and the flags through a four-entry register port. Writes are synchronous and reads are combinational. The compare register has no shadow copy, so a new value takes effect on the very next edge.

Top module: `cmp_timer`

## Requirements
- R1: After reset the counter, the compare register, the control register, both flags and the waveform pin all read zero.
- R2: In free-running mode (mode value 0) every strobed edge adds one to the count, and the count goes from 0xFF to 0x00.
- R3: The overflow flag (bit 0 of register 3) is set on the strobed edge at which the count goes from 0xFF to 0x00, and it stays set until it is cleared.
- R4: A flag is cleared by a one-cycle pulse on its acknowledge input, or by writing 1 to its bit in register 3 (bit 0 overflow, bit 1 match). If a hardware set and a clear fall on the same edge, the set wins.
- R5: In match-clear mode (mode value 2) the count rises to the compare value and becomes zero on the next strobed edge.
- R6: The match flag (bit 1 of register 3) is set on every strobed edge at which the count equals the compare value.
- R7: The action field is register 2 bits [3:2]. Its values are 0 = pin unchanged, 1 = toggle, 2 = clear and 3 = set, and each is applied to the pin on a match edge. The action field never changes the count sequence.
- R8: A write to the compare register (register 1) takes effect on the next edge. If the new value is below the current count in match-clear mode, the counter runs on to 0xFF, wraps to 0x00 with the overflow flag set, and matches on the next pass.
- R9: A write to the counter (register 0) loads the written value in place of that edge's count step. It also suppresses any match, flag or pin action on that edge.
- R10: Mode values 1 and 3 (register 2 bits [1:0]) count exactly as free-running mode does.
- R11: When the strobe is low and the counter is not written, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Prescaled count-enable strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 counter, 1 compare, 2 control, 3 flags |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| ack_ovf | input | 1 | Interrupt acknowledge that clears the overflow flag |
| ack_cmp | input | 1 | Interrupt acknowledge that clears the match flag |
| wave_out | output | 1 | Compare-driven waveform pin |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare-match flag |

## Verification
A wrong count step shows at the very next strobed edge as a counter readback that differs from the expected value. It then moves the match edge, so the pin and the match flag change in the wrong period. A lost or spurious match leaves the pin at the wrong level, and that error persists until the next match. Under toggle it persists for a whole period, so a pin check after each period catches it within one period. An overflow-flag fault shows right away on a flag readback, because the flag is sticky: an early set or a missed set stays visible until it is acknowledged.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

   typedef enum logic [1:0] {
      WM_FREE  = 2'd0,
      WM_PWM_A = 2'd1,
      WM_CTC   = 2'd2,
      WM_PWM_B = 2'd3
   } wmode_t;

   typedef enum logic [1:0] {
      ACT_NONE   = 2'd0,
      ACT_TOGGLE = 2'd1,
      ACT_CLEAR  = 2'd2,
      ACT_SET    = 2'd3
   } pin_act_t;

   localparam int ADDR_W  = 2;
   localparam logic [ADDR_W-1:0] REG_CNT = 2'd0;
   localparam logic [ADDR_W-1:0] REG_TOP = 2'd1;
   localparam logic [ADDR_W-1:0] REG_CTL = 2'd2;
   localparam logic [ADDR_W-1:0] REG_FLG = 2'd3;

   localparam int NUM_FLAGS = 2;
   localparam int FLG_OVF   = 0;
   localparam int FLG_CMP   = 1;

endpackage

// File: rtl/cmp_timer_count.sv
module cmp_timer_count #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             clear_on_match,
   input  logic             match,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_d;

   assign wrap = tick && !load && (cnt == CNT_MAX);

   always_comb begin
      cnt_d = cnt;
      if (load)
         cnt_d = load_val;
      else if (tick) begin
         if (clear_on_match && match)
            cnt_d = '0;
         else
            cnt_d = cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else
         cnt <= cnt_d;
   end
endmodule

// File: rtl/cmp_timer_pin.sv
module cmp_timer_pin #(
   parameter int CNT_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tick,
   input  logic                     load,
   input  logic [CNT_W-1:0]         cnt,
   input  logic [CNT_W-1:0]         top,
   input  cmp_timer_pkg::pin_act_t  act,
   output logic                     match,
   output logic                     wave
);
   import cmp_timer_pkg::*;

   logic wave_d;

   assign match = tick && !load && (cnt == top);

   always_comb begin
      wave_d = wave;
      if (match) begin
         unique case (act)
            ACT_TOGGLE: wave_d = !wave;
            ACT_CLEAR:  wave_d = 1'b0;
            ACT_SET:    wave_d = 1'b1;
            default:    wave_d = wave;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wave <= 1'b0;
      else
         wave <= wave_d;
   end
endmodule

// File: rtl/cmp_timer_flags.sv
module cmp_timer_flags #(
   parameter int NF           = 2,
   parameter bit SET_PRIORITY = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] set,
   input  logic [NF-1:0] clr,
   output logic [NF-1:0] q
);
   for (genvar i = 0; i < NF; i++) begin : g_flag
      if (SET_PRIORITY) begin : g_set_wins
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q[i] <= 1'b0;
            else if (set[i]) q[i] <= 1'b1;
            else if (clr[i]) q[i] <= 1'b0;
         end
      end else begin : g_clr_wins
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q[i] <= 1'b0;
            else if (clr[i]) q[i] <= 1'b0;
            else if (set[i]) q[i] <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer #(
   parameter int CNT_W        = 8,
   parameter bit SET_PRIORITY = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             bus_wr,
   input  logic [1:0]       bus_addr,
   input  logic [CNT_W-1:0] bus_wdata,
   output logic [CNT_W-1:0] bus_rdata,
   input  logic             ack_ovf,
   input  logic             ack_cmp,
   output logic             wave_out,
   output logic             ovf_flag,
   output logic             cmp_flag
);
   import cmp_timer_pkg::*;

   if (CNT_W < 4) begin : g_bad_width
      $error("cmp_timer: CNT_W must be at least 4 to hold the control field");
   end

   logic [CNT_W-1:0]     cnt_q;
   logic [CNT_W-1:0]     cmp_q;
   wmode_t               mode_q;
   pin_act_t             act_q;
   logic                 cnt_wr;
   logic                 top_wr;
   logic                 ctl_wr;
   logic                 flg_wr;
   logic                 match;
   logic                 wrap;
   logic                 ctc_on;
   logic [NUM_FLAGS-1:0] flg_set;
   logic [NUM_FLAGS-1:0] flg_clr;
   logic [NUM_FLAGS-1:0] flg_q;

   assign cnt_wr = bus_wr && (bus_addr == REG_CNT);
   assign top_wr = bus_wr && (bus_addr == REG_TOP);
   assign ctl_wr = bus_wr && (bus_addr == REG_CTL);
   assign flg_wr = bus_wr && (bus_addr == REG_FLG);
   assign ctc_on = (mode_q == WM_CTC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q  <= '0;
         mode_q <= WM_FREE;
         act_q  <= ACT_NONE;
      end else begin
         if (top_wr) cmp_q <= bus_wdata;
         if (ctl_wr) begin
            mode_q <= wmode_t'(bus_wdata[1:0]);
            act_q  <= pin_act_t'(bus_wdata[3:2]);
         end
      end
   end

   cmp_timer_count #(.CNT_W(CNT_W)) u_count (
      .clk            (clk),
      .rst_n          (rst_n),
      .tick           (tick),
      .load           (cnt_wr),
      .load_val       (bus_wdata),
      .clear_on_match (ctc_on),
      .match          (match),
      .cnt            (cnt_q),
      .wrap           (wrap)
   );

   cmp_timer_pin #(.CNT_W(CNT_W)) u_pin (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .load  (cnt_wr),
      .cnt   (cnt_q),
      .top   (cmp_q),
      .act   (act_q),
      .match (match),
      .wave  (wave_out)
   );

   always_comb begin
      flg_set          = '0;
      flg_set[FLG_OVF] = wrap;
      flg_set[FLG_CMP] = match;
      flg_clr          = '0;
      flg_clr[FLG_OVF] = ack_ovf || (flg_wr && bus_wdata[FLG_OVF]);
      flg_clr[FLG_CMP] = ack_cmp || (flg_wr && bus_wdata[FLG_CMP]);
   end

   cmp_timer_flags #(.NF(NUM_FLAGS), .SET_PRIORITY(SET_PRIORITY)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (flg_set),
      .clr   (flg_clr),
      .q     (flg_q)
   );

   assign ovf_flag = flg_q[FLG_OVF];
   assign cmp_flag = flg_q[FLG_CMP];

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         REG_CNT: bus_rdata = cnt_q;
         REG_TOP: bus_rdata = cmp_q;
         REG_CTL: begin
            bus_rdata[1:0] = mode_q;
            bus_rdata[3:2] = act_q;
         end
         default: bus_rdata[NUM_FLAGS-1:0] = flg_q;
      endcase
   end
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             cnt_wr,
   input logic [CNT_W-1:0] wdata,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] top,
   input logic [1:0]       mode,
   input logic [1:0]       act,
   input logic             wave,
   input logic             ovf,
   input logic             cmpf
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !cnt_wr) |=> $stable(cnt));

   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_wr && !(mode == 2'd2 && cnt == top)) |=> (cnt == $past(cnt) + 1'b1));

   p_wrap_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_wr && cnt == CMAX) |=> ovf);

   p_ctc_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_wr && mode == 2'd2 && cnt == top) |=> (cnt == '0));

   p_match_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_wr && cnt == top) |=> cmpf);

   p_pin_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_wr && cnt == top && act == 2'd3) |=> wave);

   p_pin_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_wr && cnt == top && act == 2'd1) |=> (wave != $past(wave)));

   p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (cnt == $past(wdata) && $stable(wave)));
endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .tick   (tick),
   .cnt_wr (cnt_wr),
   .wdata  (bus_wdata),
   .cnt    (cnt_q),
   .top    (cmp_q),
   .mode   (mode_q),
   .act    (act_q),
   .wave   (wave_out),
   .ovf    (ovf_flag),
   .cmpf   (cmp_flag)
);

// File: tb/cmp_timer_test.sv
module cmp_timer_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       ack_ovf = 1'b0;
   logic       ack_cmp = 1'b0;
   logic       wave_out;
   logic       ovf_flag;
   logic       cmp_flag;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   typedef struct {
      int         kind;
      logic [7:0] exp;
      string      req;
   } item_t;

   item_t sb[$];

   always #10 clk = !clk;

   cmp_timer uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ack_ovf(ack_ovf), .ack_cmp(ack_cmp), .wave_out(wave_out),
      .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
   );

   // monitor: pops one expectation per falling edge
   always @(negedge clk) begin
      if (sb.size() != 0) begin
         item_t it;
         logic [7:0] got;
         it = sb.pop_front();
         got = (it.kind == 4) ? {7'd0, wave_out} : bus_rdata;
         total++;
         if (got !== it.exp) begin
            fails++;
            $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, got, it.exp);
         end
      end
   end

   task automatic chk(input int kind, input logic [7:0] exp, input string req);
      item_t it;
      if (kind < 4) bus_addr = kind[1:0];
      it.kind = kind; it.exp = exp; it.req = req;
      sb.push_back(it);
      @(negedge clk); #1;
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1;
         @(posedge clk); #1;
         tick = 1'b0;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog: run did not finish");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(posedge clk); #1;
      // R1 reset state
      chk(0, 8'h00, "R1"); chk(1, 8'h00, "R1"); chk(2, 8'h00, "R1");
      chk(3, 8'h00, "R1"); chk(4, 8'h00, "R1");

      // R2 free-running count, R11 hold
      step(5);  chk(0, 8'd5, "R2");
      idle(4);  chk(0, 8'd5, "R11");
      wr(2'd3, 8'h03); chk(3, 8'h00, "R4");

      // R9 counter load, R3 overflow on wrap
      wr(2'd0, 8'hFD); chk(0, 8'hFD, "R9");
      step(2); chk(0, 8'hFF, "R2"); chk(3, 8'h00, "R3");
      step(1); chk(0, 8'h00, "R2"); chk(3, 8'h01, "R3");
      step(3); chk(3, 8'h03, "R3");

      // R4 acknowledge and write-one clears, set wins
      ack_ovf = 1'b1; @(posedge clk); #1; ack_ovf = 1'b0;
      chk(3, 8'h02, "R4");
      ack_cmp = 1'b1; @(posedge clk); #1; ack_cmp = 1'b0;
      chk(3, 8'h00, "R4");
      wr(2'd0, 8'hFF);
      tick = 1'b1; ack_ovf = 1'b1; @(posedge clk); #1; tick = 1'b0; ack_ovf = 1'b0;
      chk(3, 8'h01, "R4");
      wr(2'd3, 8'h01); chk(3, 8'h00, "R4");

      // R5 R6 R7 match-clear with toggle
      wr(2'd2, 8'h06); wr(2'd1, 8'd3); wr(2'd0, 8'd0); wr(2'd3, 8'h03);
      step(3); chk(0, 8'd3, "R5"); chk(3, 8'h00, "R6");
      step(1); chk(0, 8'd0, "R5"); chk(3, 8'h02, "R6"); chk(4, 8'd1, "R7");
      step(4); chk(4, 8'd0, "R7"); chk(0, 8'd0, "R5"); chk(3, 8'h02, "R5");

      // R7 set, none, clear
      wr(2'd2, 8'h0E); step(4); chk(4, 8'd1, "R7");
      wr(2'd2, 8'h02); step(4); chk(4, 8'd1, "R7"); chk(0, 8'd0, "R7");
      wr(2'd2, 8'h0A); step(4); chk(4, 8'd0, "R7");

      // R8 compare written below the count
      wr(2'd1, 8'd200); step(5); chk(0, 8'd5, "R8");
      wr(2'd1, 8'd2); wr(2'd3, 8'h03);
      step(250); chk(0, 8'hFF, "R8"); chk(3, 8'h00, "R8");
      step(1);   chk(0, 8'h00, "R8"); chk(3, 8'h01, "R8");
      step(2);   chk(0, 8'd2, "R8");
      step(1);   chk(0, 8'h00, "R8"); chk(3, 8'h03, "R8");

      // R9 load suppresses a match on the same edge
      wr(2'd2, 8'h06); wr(2'd3, 8'h03);
      step(2); chk(0, 8'd2, "R9");
      tick = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'd7;
      @(posedge clk); #1; tick = 1'b0; bus_wr = 1'b0;
      chk(0, 8'd7, "R9"); chk(4, 8'd0, "R9"); chk(3, 8'h00, "R9");

      // R10 PWM mode values count freely
      wr(2'd2, 8'h01); wr(2'd0, 8'd0); step(3); chk(0, 8'd3, "R10");
      wr(2'd2, 8'h03); wr(2'd0, 8'd0); step(3); chk(0, 8'd3, "R10");

      idle(2);
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule